// File: doc/BRIEF.md
# Chainable Vectored Interrupt Controller

This block takes a set of level-sensitive interrupt request lines and, every clock cycle, chooses the most urgent one that is pending and allowed. For the chosen line it builds a descriptor and presents it to the processor on a streaming output. The descriptor holds the line's priority level, a register-set number, a non-maskable flag and a handler address. The handler address is a programmable base plus the line index scaled by a programmable power-of-two vector spacing.

Software reaches the per-line settings through a small memory-mapped register port. That port also holds a global enable, an enable mask with one bit per line, the vector base and the spacing selector. A level of zero switches a line off.

A second descriptor can arrive on a streaming input from another controller of the same kind. The block forwards that upstream descriptor only when its level is strictly higher than the local winner's level. Controllers can therefore be chained so that one processor serves more lines than a single instance holds.

Top module: `irqv_top`

## Requirements
- R1: When an eligible line is pending at a rising edge, `outValid` is high from the next rising edge on. A line is eligible when it is requested, its mask bit is set, the global enable is set and its level is nonzero.
- R2: A line whose programmed level is 0 never wins, even when it is requested and enabled.
- R3: Among eligible pending lines, the one with the highest level wins. On equal levels the lowest line index wins.
- R4: While the global enable (register word 0, bit 0) is 0, no local line wins.
- R5: A line whose bit in the mask register (word 1, bit n for line n) is 0 never wins.
- R6: A local winner's descriptor carries that line's register-set number and non-maskable flag. The line word at address 32+n holds the level in bits [7:0], the register set in bits [15:8] and the non-maskable flag in bit 16.
- R7: A local winner's handler address equals base (word 2) plus the line index shifted left by 4+s, where s is bits [1:0] of word 3. This gives spacings of 16, 32, 64 and 128 bytes.
- R8: A valid upstream descriptor with a level strictly greater than the local winner's is forwarded with all four fields unchanged. On an equal or lower level the local winner is forwarded.
- R9: An upstream descriptor that is not valid, or whose level is 0, has no effect. `outValid` is low when nothing is pending.
- R10: Every configuration register reads back through `csrRdata` at its own address, combinationally. Writes to a line number at or beyond the line count are ignored.
- R11: After reset, `outValid` is 0 and every configuration register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | NUM_LINES | Level-sensitive interrupt requests |
| csrAddr | input | CSR_AW | Register word address |
| csrWrite | input | 1 | Write strobe for one cycle |
| csrWdata | input | 32 | Write data |
| csrRdata | output | 32 | Read data for csrAddr |
| upValid | input | 1 | Upstream descriptor valid |
| upLevel | input | LEVEL_W | Upstream level |
| upRset | input | RSET_W | Upstream register-set number |
| upNmi | input | 1 | Upstream non-maskable flag |
| upRha | input | ADDR_W | Upstream handler address |
| outValid | output | 1 | Output descriptor valid |
| outLevel | output | LEVEL_W | Selected level |
| outRset | output | RSET_W | Selected register-set number |
| outNmi | output | 1 | Selected non-maskable flag |
| outRha | output | ADDR_W | Selected handler address |

## Verification
The bench builds the block with eight lines, 3-bit levels, 4-bit register-set numbers and 16-bit addresses. At that size every one of the 256 request patterns can be applied under several configurations: distinct levels, a sparse mask, global disable and all levels equal. In each case the winner, its fields and its handler address are predicted by a plain scan in the bench. The 3-bit level range lets every upstream level be tried against a local winner, both above and below it and equal to it, and also with no local winner at all. All four spacing settings are covered as well.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_GLOBAL,
    RD_MASK,
    RD_BASE,
    RD_SPACING,
    RD_LINE
  } rdKind_t;

  // Decoded register access handed from control to datapath
  typedef struct packed {
    logic        wrGlobal;
    logic        wrMask;
    logic        wrBase;
    logic        wrSpacing;
    logic        wrLine;
    rdKind_t     rdKind;
    logic [4:0]  lineIdx;
    logic [31:0] data;
  } csrStrobe_t;

  localparam int unsigned LINE_WORD_BASE = 32;

endpackage

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned CSR_AW    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CSR_AW-1:0] csrAddr,
  input  logic              csrWrite,
  input  logic [31:0]       csrWdata,
  output csrStrobe_t        strb
);

  logic [CSR_AW-1:0] lineOff;
  logic              isLine;

  assign lineOff = csrAddr - CSR_AW'(LINE_WORD_BASE);
  assign isLine  = (csrAddr >= CSR_AW'(LINE_WORD_BASE)) &&
                   (lineOff < CSR_AW'(NUM_LINES));

  always_comb begin
    strb         = '0;
    strb.data    = csrWdata;
    strb.lineIdx = 5'(lineOff);
    strb.rdKind  = RD_NONE;
    if (isLine) begin
      strb.rdKind = RD_LINE;
      strb.wrLine = csrWrite;
    end else begin
      case (csrAddr)
        CSR_AW'(0): begin strb.rdKind = RD_GLOBAL;  strb.wrGlobal  = csrWrite; end
        CSR_AW'(1): begin strb.rdKind = RD_MASK;    strb.wrMask    = csrWrite; end
        CSR_AW'(2): begin strb.rdKind = RD_BASE;    strb.wrBase    = csrWrite; end
        CSR_AW'(3): begin strb.rdKind = RD_SPACING; strb.wrSpacing = csrWrite; end
        default: ;
      endcase
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrGlobal, strb.wrMask, strb.wrBase, strb.wrSpacing, strb.wrLine})); // R10

  AST_LINE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLine |-> (32'(strb.lineIdx) < NUM_LINES)); // R10

endmodule

// File: rtl/irqv_datapath.sv
module irqv_datapath
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned LEVEL_W   = 6,
  parameter int unsigned RSET_W    = 6,
  parameter int unsigned ADDR_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  csrStrobe_t           strb,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic                 upValid,
  input  logic [LEVEL_W-1:0]   upLevel,
  input  logic [RSET_W-1:0]    upRset,
  input  logic                 upNmi,
  input  logic [ADDR_W-1:0]    upRha,
  output logic [31:0]          csrRdata,
  output logic                 outValid,
  output logic [LEVEL_W-1:0]   outLevel,
  output logic [RSET_W-1:0]    outRset,
  output logic                 outNmi,
  output logic [ADDR_W-1:0]    outRha
);

  localparam int unsigned IDX_W = $clog2(NUM_LINES);

  logic [LEVEL_W-1:0]   cfgLevel [NUM_LINES];
  logic [RSET_W-1:0]    cfgRset  [NUM_LINES];
  logic                 cfgNmi   [NUM_LINES];
  logic                 globalEn;
  logic [NUM_LINES-1:0] maskReg;
  logic [ADDR_W-1:0]    baseReg;
  logic [1:0]           spacingSel;

  logic [NUM_LINES-1:0] eligible;
  logic [LEVEL_W-1:0]   bestLevel;
  logic [IDX_W-1:0]     bestIdx;
  logic                 locValid;
  logic [ADDR_W-1:0]    locRha;
  logic                 upLive;
  logic                 takeUp;
  logic [IDX_W-1:0]     selIdx;

  assign selIdx = strb.lineIdx[IDX_W-1:0];

  // Configuration storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn   <= 1'b0;
      maskReg    <= '0;
      baseReg    <= '0;
      spacingSel <= '0;
      for (int i = 0; i < NUM_LINES; i++) begin
        cfgLevel[i] <= '0;
        cfgRset[i]  <= '0;
        cfgNmi[i]   <= 1'b0;
      end
    end else begin
      if (strb.wrGlobal)  globalEn   <= strb.data[0];
      if (strb.wrMask)    maskReg    <= strb.data[NUM_LINES-1:0];
      if (strb.wrBase)    baseReg    <= strb.data[ADDR_W-1:0];
      if (strb.wrSpacing) spacingSel <= strb.data[1:0];
      if (strb.wrLine) begin
        cfgLevel[selIdx] <= strb.data[LEVEL_W-1:0];
        cfgRset[selIdx]  <= strb.data[8 +: RSET_W];
        cfgNmi[selIdx]   <= strb.data[16];
      end
    end
  end

  // Readback
  always_comb begin
    csrRdata = '0;
    case (strb.rdKind)
      RD_GLOBAL:  csrRdata[0]             = globalEn;
      RD_MASK:    csrRdata[NUM_LINES-1:0] = maskReg;
      RD_BASE:    csrRdata[ADDR_W-1:0]    = baseReg;
      RD_SPACING: csrRdata[1:0]           = spacingSel;
      RD_LINE: begin
        csrRdata[LEVEL_W-1:0] = cfgLevel[selIdx];
        csrRdata[8 +: RSET_W] = cfgRset[selIdx];
        csrRdata[16]          = cfgNmi[selIdx];
      end
      default: ;
    endcase
  end

  // Per-line eligibility
  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    assign eligible[g] = irqLines[g] && maskReg[g] && globalEn && (cfgLevel[g] != '0);
  end

  // Priority scan: strict compare keeps the lowest index on ties
  always_comb begin
    bestLevel = '0;
    bestIdx   = '0;
    locValid  = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (eligible[i] && (cfgLevel[i] > bestLevel)) begin
        bestLevel = cfgLevel[i];
        bestIdx   = IDX_W'(i);
        locValid  = 1'b1;
      end
    end
  end

  assign locRha = baseReg + (ADDR_W'(bestIdx) << (3'd4 + {1'b0, spacingSel}));
  assign upLive = upValid && (upLevel != '0);
  assign takeUp = upLive && (upLevel > bestLevel);

  // Registered descriptor
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outLevel <= '0;
      outRset  <= '0;
      outNmi   <= 1'b0;
      outRha   <= '0;
    end else begin
      outValid <= takeUp || locValid;
      if (takeUp) begin
        outLevel <= upLevel;
        outRset  <= upRset;
        outNmi   <= upNmi;
        outRha   <= upRha;
      end else begin
        outLevel <= bestLevel;
        outRset  <= cfgRset[bestIdx];
        outNmi   <= cfgNmi[bestIdx];
        outRha   <= locRha;
      end
    end
  end

  AST_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outLevel != '0)); // R2

  AST_GLOBAL_GATES: assert property (@(posedge clk) disable iff (!rstN)
    (!globalEn && !upLive) |=> !outValid); // R4

  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rstN)
    (locValid && !takeUp) |-> maskReg[bestIdx]); // R5

  AST_UP_PASSTHRU: assert property (@(posedge clk) disable iff (!rstN)
    (upLive && !locValid) |=> (outValid && outLevel == $past(upLevel) && outRha == $past(upRha))); // R8

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!locValid && !upLive) |=> !outValid); // R9

  AST_PENDING_SEEN: assert property (@(posedge clk) disable iff (!rstN)
    (|eligible) |=> outValid); // R1

endmodule

// File: rtl/irqv_top.sv
module irqv_top
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned LEVEL_W   = 6,
  parameter int unsigned RSET_W    = 6,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CSR_AW    = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [CSR_AW-1:0]    csrAddr,
  input  logic                 csrWrite,
  input  logic [31:0]          csrWdata,
  output logic [31:0]          csrRdata,
  input  logic                 upValid,
  input  logic [LEVEL_W-1:0]   upLevel,
  input  logic [RSET_W-1:0]    upRset,
  input  logic                 upNmi,
  input  logic [ADDR_W-1:0]    upRha,
  output logic                 outValid,
  output logic [LEVEL_W-1:0]   outLevel,
  output logic [RSET_W-1:0]    outRset,
  output logic                 outNmi,
  output logic [ADDR_W-1:0]    outRha
);

  csrStrobe_t strb;

  irqv_ctrl #(.NUM_LINES(NUM_LINES), .CSR_AW(CSR_AW)) uCtrl (
    .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrWrite(csrWrite),
    .csrWdata(csrWdata), .strb(strb)
  );

  irqv_datapath #(
    .NUM_LINES(NUM_LINES), .LEVEL_W(LEVEL_W), .RSET_W(RSET_W), .ADDR_W(ADDR_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .irqLines(irqLines),
    .upValid(upValid), .upLevel(upLevel), .upRset(upRset), .upNmi(upNmi), .upRha(upRha),
    .csrRdata(csrRdata), .outValid(outValid), .outLevel(outLevel),
    .outRset(outRset), .outNmi(outNmi), .outRha(outRha)
  );

endmodule

// File: tb/sim_irqv_top.sv
`timescale 1ns/1ps
module sim_irqv_top;

  localparam int NL = 8;
  localparam int LW = 3;
  localparam int RW = 4;
  localparam int AW = 16;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NL-1:0] irqLines = '0;
  logic [CW-1:0] csrAddr = '0;
  logic          csrWrite = 1'b0;
  logic [31:0]   csrWdata = '0;
  logic [31:0]   csrRdata;
  logic          upValid = 1'b0;
  logic [LW-1:0] upLevel = '0;
  logic [RW-1:0] upRset = '0;
  logic          upNmi = 1'b0;
  logic [AW-1:0] upRha = '0;
  logic          outValid;
  logic [LW-1:0] outLevel;
  logic [RW-1:0] outRset;
  logic          outNmi;
  logic [AW-1:0] outRha;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench-side model of programmed state
  int mLevel [NL];
  int mRset  [NL];
  int mNmi   [NL];
  int mGlobal = 0;
  int mMask = 0;
  int mBase = 0;
  int mSpace = 0;

  always #2 clk = ~clk;

  irqv_top #(.NUM_LINES(NL), .LEVEL_W(LW), .RSET_W(RW), .ADDR_W(AW), .CSR_AW(CW)) u0 (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .csrAddr(csrAddr), .csrWrite(csrWrite),
    .csrWdata(csrWdata), .csrRdata(csrRdata), .upValid(upValid), .upLevel(upLevel),
    .upRset(upRset), .upNmi(upNmi), .upRha(upRha), .outValid(outValid),
    .outLevel(outLevel), .outRset(outRset), .outNmi(outNmi), .outRha(outRha)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic csrWr(input int addr, input int data);
    @(negedge clk);
    csrAddr = CW'(addr); csrWdata = 32'(data); csrWrite = 1'b1;
    @(negedge clk);
    csrWrite = 1'b0;
    case (addr)
      0: mGlobal = data & 1;
      1: mMask = data & 8'hFF;
      2: mBase = data & 16'hFFFF;
      3: mSpace = data & 3;
      default: if (addr >= 32 && addr < 32 + NL) begin
        mLevel[addr-32] = data & 7;
        mRset[addr-32]  = (data >> 8) & 15;
        mNmi[addr-32]   = (data >> 16) & 1;
      end
    endcase
  endtask

  task automatic csrRdCheck(input string req, input int addr, input int exp);
    @(negedge clk);
    csrAddr = CW'(addr);
    #1;
    check(req, 64'(csrRdata), 64'(exp));
  endtask

  // Apply request pattern and upstream, then compare against the bench model
  task automatic applyAndCheck(input string req, input int irq);
    int bl, bi, ev;
    logic [63:0] exp;
    @(negedge clk);
    irqLines = NL'(irq);
    bl = 0; bi = 0;
    for (int i = 0; i < NL; i++) begin
      if (((irq >> i) & 1) && ((mMask >> i) & 1) && mGlobal && mLevel[i] > bl) begin
        bl = mLevel[i]; bi = i;
      end
    end
    if (upValid && upLevel != 0 && int'(upLevel) > bl) begin
      ev = 1;
      exp = {1'b1, 3'(upLevel), 4'(upRset), upNmi, 16'(upRha)};
    end else if (bl != 0) begin
      ev = 1;
      exp = {1'b1, 3'(bl), 4'(mRset[bi]), 1'(mNmi[bi]), 16'(mBase + (bi << (4 + mSpace)))};
    end else begin
      ev = 0;
      exp = 0;
    end
    @(negedge clk);
    if (ev) check(req, {outValid, outLevel, outRset, outNmi, outRha}, exp);
    else    check(req, 64'(outValid), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin mLevel[i] = 0; mRset[i] = 0; mNmi[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 outValid", 64'(outValid), 0);
    csrRdCheck("R11 global", 0, 0);
    csrRdCheck("R11 mask", 1, 0);
    csrRdCheck("R11 base", 2, 0);
    csrRdCheck("R11 line3", 35, 0);

    // Program distinct levels: 3,0,5,2,7,4,1,6
    for (int i = 0; i < NL; i++)
      csrWr(32 + i, ((i * 5 + 3) % 8) | (((i + 1) % 16) << 8) | ((i & 1) << 16));
    csrWr(2, 16'h1000);
    csrWr(3, 1);
    csrWr(1, 8'hFF);
    csrWr(0, 1);
    csrWr(32 + NL, 7);  // out-of-range line, ignored
    // R10 readback
    csrRdCheck("R10 global", 0, 1);
    csrRdCheck("R10 mask", 1, 8'hFF);
    csrRdCheck("R10 base", 2, 16'h1000);
    csrRdCheck("R10 spacing", 3, 1);
    csrRdCheck("R10 line4", 36, 7 | (5 << 8) | (0 << 16));
    csrRdCheck("R10 line5", 37, 4 | (6 << 8) | (1 << 16));
    csrRdCheck("R10 outofrange", 32 + NL, 0);

    // R1 R2 R3 R6 R7: all patterns, full mask (line1 level 0 covers R2)
    for (int p = 0; p < 256; p++) applyAndCheck("R1_R2_R3_R6_R7 sweep", p);
    applyAndCheck("R2 zero-level line alone", 8'h02);

    // R5 sparse mask
    csrWr(1, 8'hA5);
    for (int p = 0; p < 256; p++) applyAndCheck("R5 mask sweep", p);
    applyAndCheck("R5 masked line4 alone", 8'h10);

    // R4 global off
    csrWr(1, 8'hFF);
    csrWr(0, 0);
    for (int p = 0; p < 256; p += 17) applyAndCheck("R4 global off", p);
    csrWr(0, 1);

    // R3 ties: all levels equal
    for (int i = 0; i < NL; i++) csrWr(32 + i, 4 | (i << 8));
    for (int p = 0; p < 256; p++) applyAndCheck("R3 tie sweep", p);

    // R7 all spacings
    for (int s = 0; s < 4; s++) begin
      csrWr(3, s);
      applyAndCheck("R7 spacing line7", 8'h80);
      applyAndCheck("R7 spacing line5", 8'h20);
    end

    // R8 R9 upstream merging; local line2 level 5
    for (int i = 0; i < NL; i++) csrWr(32 + i, ((i * 5 + 3) % 8) | (((i + 1) % 16) << 8));
    upRset = 4'hA; upNmi = 1'b1; upRha = 16'hBEEF;
    for (int v = 0; v < 2; v++) begin
      for (int l = 0; l < 8; l++) begin
        upValid = 1'(v); upLevel = 3'(l);
        applyAndCheck("R8 upstream vs local", 8'h04);
        applyAndCheck("R9 upstream alone", 8'h00);
      end
    end
    upValid = 1'b0;
    applyAndCheck("R9 idle", 8'h00);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule